// File: doc/BRIEF.md
# ATAN2 Special-Value Resolver

This block looks at a pair of single-precision operands, `y` and `x`, and decides whether the two-argument arctangent atan2(y, x) is fully determined by special-value rules. Those rules cover NaN operands, infinite operands and signed zeros. When a rule applies, the block raises a "special" flag. Its result word then holds either a quietened copy of the NaN operand or a fixed constant from {0, π/4, π/2, 3π/4, π}, and every constant carries the sign of `y`.

When no rule applies, "special" stays low and the caller sends the operands to a general arctangent datapath. The block sits in front of that datapath as a bypass decision. Operand classification feeds a priority controller, and the controller drives the result multiplexer through a small strobe bundle. An optional output register, selected by a parameter, adds one cycle of latency.

Top module: `atan2_special_resolver`

## Requirements
- R1: If x is a NaN (exponent all ones, fraction nonzero), the output is special and the result is x with fraction bit 22 forced to 1; the sign, exponent and other fraction bits are kept.
- R2: If x is not a NaN and y is a NaN, the output is special and the result is y with fraction bit 22 forced to 1.
- R3: The invalid flag is high exactly when a valid input pair contains at least one signalling NaN, meaning a NaN whose fraction bit 22 is 0.
- R4: With x = +∞ and neither operand NaN, y = ±∞ gives π/4 and a finite y gives 0. Both results take bit 31 from y.
- R5: With x = −∞ and neither operand NaN, y = ±∞ gives 3π/4 and a finite y gives π. Both results take bit 31 from y.
- R6: With x finite and y = ±∞, the result is π/2 with the sign of y.
- R7: With x = +0 or −0 and y finite and nonzero, the result is π/2 with the sign of y.
- R8: With y = ±0 and x finite: a clear sign bit on x (including +0) gives 0, and a set sign bit on x (including −0) gives π. Both results take the sign of y.
- R9: Subnormal operands are treated as nonzero finite values. They never trigger the zero rules of R7 and R8.
- R10: When both operands are finite and nonzero, special and invalid are low and the result word is 0x00000000.
- R11: With the register stage enabled, output valid equals input valid one cycle later. Whenever output valid is low, special, invalid and result are all 0.
- R12: The constant magnitudes, in bits 30:0, are π/4 = 0x3F490FDB, π/2 = 0x3FC90FDB, 3π/4 = 0x4016CBE4, π = 0x40490FDB and zero = 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Operand pair is valid |
| yIn | input | 32 | Operand y (numerator), single precision |
| xIn | input | 32 | Operand x (denominator), single precision |
| outValid | output | 1 | Result valid |
| outSpecial | output | 1 | atan2 fixed by a special-value rule |
| outInvalid | output | 1 | Signalling NaN seen on an input |
| outResult | output | 32 | NaN or signed constant, 0 when not special |

## Verification
The assertions assume that `yIn` is stable in the cycle in which `inValid` is sampled, so the sign of a registered constant can be compared against the `y` sign from the previous cycle. They also assume that reset holds `inValid` low. The stimulus drives every operand pair at the falling edge and keeps it stable across the following rising edge. Random operands are drawn from weighted classes: signed zeros, subnormals, normals, infinities, quiet NaNs and signalling NaNs. This reaches every priority branch, including both NaN orderings and both zero signs.

// File: rtl/atan2sp_pkg.sv
package atan2sp_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int QUIET_BIT = FRAC_W - 1;

  localparam logic [WORD_W-2:0] MAG_ZERO = 31'h00000000;
  localparam logic [WORD_W-2:0] MAG_QPI  = 31'h3F490FDB;
  localparam logic [WORD_W-2:0] MAG_HPI  = 31'h3FC90FDB;
  localparam logic [WORD_W-2:0] MAG_TQPI = 31'h4016CBE4;
  localparam logic [WORD_W-2:0] MAG_PI   = 31'h40490FDB;

  typedef enum logic [2:0] {
    CK_ZERO = 3'd0,
    CK_QPI  = 3'd1,
    CK_HPI  = 3'd2,
    CK_TQPI = 3'd3,
    CK_PI   = 3'd4
  } constKind_t;

  typedef struct packed {
    logic sign;
    logic isZero;
    logic isInf;
    logic isNan;
    logic isSnan;
  } opClass_t;

  typedef struct packed {
    logic       special;
    logic       takeNanX;
    logic       takeNanY;
    logic       invalid;
    logic       resSign;
    constKind_t constSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/atan2sp_opclass.sv
module atan2sp_opclass
  import atan2sp_pkg::*;
(
  input  logic [WORD_W-1:0] opWord,
  output opClass_t          opClass,
  output logic [WORD_W-1:0] quietWord
);
  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] fracField;
  logic              expAllOnes;
  logic              expAllZero;
  logic              fracNonZero;

  assign expField    = opWord[WORD_W-2 -: EXP_W];
  assign fracField   = opWord[FRAC_W-1:0];
  assign expAllOnes  = &expField;
  assign expAllZero  = ~|expField;
  assign fracNonZero = |fracField;

  always_comb begin
    opClass.sign   = opWord[WORD_W-1];
    opClass.isZero = expAllZero & ~fracNonZero;
    opClass.isInf  = expAllOnes & ~fracNonZero;
    opClass.isNan  = expAllOnes & fracNonZero;
    opClass.isSnan = expAllOnes & fracNonZero & ~fracField[QUIET_BIT];
  end

  always_comb begin
    quietWord            = opWord;
    quietWord[QUIET_BIT] = 1'b1;
  end
endmodule

// File: rtl/atan2sp_control.sv
module atan2sp_control
  import atan2sp_pkg::*;
(
  input  opClass_t    yClass,
  input  opClass_t    xClass,
  output ctrlStrobe_t strobe
);
  logic xFinite;
  logic yFinite;

  assign xFinite = ~xClass.isInf & ~xClass.isNan;
  assign yFinite = ~yClass.isInf & ~yClass.isNan;

  always_comb begin
    strobe          = '0;
    strobe.constSel = CK_ZERO;
    strobe.resSign  = yClass.sign;
    strobe.invalid  = xClass.isSnan | yClass.isSnan;
    if (xClass.isNan) begin
      strobe.special  = 1'b1;
      strobe.takeNanX = 1'b1;
    end else if (yClass.isNan) begin
      strobe.special  = 1'b1;
      strobe.takeNanY = 1'b1;
    end else if (xClass.isInf && !xClass.sign) begin
      strobe.special  = 1'b1;
      strobe.constSel = yClass.isInf ? CK_QPI : CK_ZERO;
    end else if (xClass.isInf) begin
      strobe.special  = 1'b1;
      strobe.constSel = yClass.isInf ? CK_TQPI : CK_PI;
    end else if (yClass.isInf) begin
      strobe.special  = 1'b1;
      strobe.constSel = CK_HPI;
    end else if (xClass.isZero && !yClass.isZero && yFinite) begin
      strobe.special  = 1'b1;
      strobe.constSel = CK_HPI;
    end else if (yClass.isZero && xFinite) begin
      strobe.special  = 1'b1;
      strobe.constSel = xClass.sign ? CK_PI : CK_ZERO;
    end
  end
endmodule

// File: rtl/atan2sp_datapath.sv
module atan2sp_datapath
  import atan2sp_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [WORD_W-1:0] yIn,
  input  logic [WORD_W-1:0] xIn,
  output opClass_t          yClass,
  output opClass_t          xClass,
  input  ctrlStrobe_t       strobe,
  output logic              outValid,
  output logic              outSpecial,
  output logic              outInvalid,
  output logic [WORD_W-1:0] outResult
);
  localparam int N_OPS = 2;

  logic [WORD_W-1:0] opWords  [N_OPS];
  logic [WORD_W-1:0] quietOps [N_OPS];
  opClass_t          classes  [N_OPS];

  assign opWords[0] = yIn;
  assign opWords[1] = xIn;

  for (genvar i = 0; i < N_OPS; i++) begin : g_cls
    atan2sp_opclass u_cls (
      .opWord   (opWords[i]),
      .opClass  (classes[i]),
      .quietWord(quietOps[i])
    );
  end

  assign yClass = classes[0];
  assign xClass = classes[1];

  function automatic logic [WORD_W-2:0] constMag(input constKind_t k);
    case (k)
      CK_QPI:  constMag = MAG_QPI;
      CK_HPI:  constMag = MAG_HPI;
      CK_TQPI: constMag = MAG_TQPI;
      CK_PI:   constMag = MAG_PI;
      default: constMag = MAG_ZERO;
    endcase
  endfunction

  logic              nxtSpecial;
  logic              nxtInvalid;
  logic [WORD_W-1:0] nxtResult;

  always_comb begin
    nxtSpecial = 1'b0;
    nxtInvalid = 1'b0;
    nxtResult  = '0;
    if (inValid) begin
      nxtSpecial = strobe.special;
      nxtInvalid = strobe.invalid;
      if (strobe.takeNanX)      nxtResult = quietOps[1];
      else if (strobe.takeNanY) nxtResult = quietOps[0];
      else if (strobe.special)  nxtResult = {strobe.resSign, constMag(strobe.constSel)};
    end
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outValid   <= 1'b0;
        outSpecial <= 1'b0;
        outInvalid <= 1'b0;
        outResult  <= '0;
      end else begin
        outValid   <= inValid;
        outSpecial <= nxtSpecial;
        outInvalid <= nxtInvalid;
        outResult  <= nxtResult;
      end
    end
  end else begin : g_comb
    assign outValid   = inValid;
    assign outSpecial = nxtSpecial;
    assign outInvalid = nxtInvalid;
    assign outResult  = nxtResult;
  end
endmodule

// File: rtl/atan2_special_resolver.sv
module atan2_special_resolver
  import atan2sp_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] yIn,
  input  logic [31:0] xIn,
  output logic        outValid,
  output logic        outSpecial,
  output logic        outInvalid,
  output logic [31:0] outResult
);
  opClass_t    yClass;
  opClass_t    xClass;
  ctrlStrobe_t strobe;

  atan2sp_control u_ctrl (
    .yClass(yClass),
    .xClass(xClass),
    .strobe(strobe)
  );

  atan2sp_datapath #(.REG_OUT(REG_OUT)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .yIn       (yIn),
    .xIn       (xIn),
    .yClass    (yClass),
    .xClass    (xClass),
    .strobe    (strobe),
    .outValid  (outValid),
    .outSpecial(outSpecial),
    .outInvalid(outInvalid),
    .outResult (outResult)
  );
endmodule

// File: rtl/atan2sp_checker.sv
module atan2sp_checker #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [31:0] yIn,
  input logic        outValid,
  input logic        outSpecial,
  input logic        outInvalid,
  input logic [31:0] outResult
);
  logic resIsNan;
  assign resIsNan = (&outResult[30:23]) && (|outResult[22:0]);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!outSpecial && !outInvalid && outResult == 32'h0)); // R11

  AST_NAN_QUIETENED: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && resIsNan) |-> outResult[22]); // R1

  AST_INVALID_HAS_NAN: assert property (@(posedge clk) disable iff (!rstN)
    outInvalid |-> (outSpecial && resIsNan)); // R3

  AST_GENERAL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outSpecial) |-> (outResult == 32'h0 && !outInvalid)); // R10

  if (REG_OUT) begin : g_reg
    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
      outValid == $past(inValid)); // R11

    AST_CONST_SIGN: assert property (@(posedge clk) disable iff (!rstN)
      (outValid && outSpecial && !resIsNan) |-> outResult[31] == $past(yIn[31])); // R4
  end else begin : g_comb
    AST_CONST_SIGN: assert property (@(posedge clk) disable iff (!rstN)
      (outValid && outSpecial && !resIsNan) |-> outResult[31] == yIn[31]); // R4
  end
endmodule

bind atan2_special_resolver atan2sp_checker #(.REG_OUT(REG_OUT)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .yIn       (yIn),
  .outValid  (outValid),
  .outSpecial(outSpecial),
  .outInvalid(outInvalid),
  .outResult (outResult)
);

// File: tb/atan2_special_resolver_test.sv
`timescale 1ns/1ps
module atan2_special_resolver_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] yIn = '0;
  logic [31:0] xIn = '0;
  logic        outValid;
  logic        outSpecial;
  logic        outInvalid;
  logic [31:0] outResult;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  atan2_special_resolver #(.REG_OUT(1'b1)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .yIn(yIn), .xIn(xIn),
    .outValid(outValid), .outSpecial(outSpecial), .outInvalid(outInvalid),
    .outResult(outResult)
  );

  function automatic bit fNan(input logic [31:0] w);
    return (w[30:23] == 8'hFF) && (w[22:0] != 0);
  endfunction
  function automatic bit fInf(input logic [31:0] w);
    return (w[30:23] == 8'hFF) && (w[22:0] == 0);
  endfunction
  function automatic bit fZero(input logic [31:0] w);
    return w[30:0] == 31'h0;
  endfunction

  // Reference model from the requirements; returns the tag of the rule used.
  function automatic string refModel(input logic [31:0] y, input logic [31:0] x,
                                     output bit sp, output bit inv,
                                     output logic [31:0] res);
    string tag;
    logic [30:0] mag;
    inv = (fNan(x) && !x[22]) || (fNan(y) && !y[22]);
    sp  = 1'b1;
    res = 32'h0;
    mag = 31'h0;
    if (fNan(x)) begin
      res = x | 32'h0040_0000; tag = "R1";
      return inv ? "R3" : tag;
    end
    if (fNan(y)) begin
      res = y | 32'h0040_0000; tag = "R2";
      return inv ? "R3" : tag;
    end
    if (fInf(x)) begin
      if (!x[31]) begin mag = fInf(y) ? 31'h3F490FDB : 31'h0; tag = "R4"; end
      else        begin mag = fInf(y) ? 31'h4016CBE4 : 31'h40490FDB; tag = "R5"; end
    end else if (fInf(y)) begin
      mag = 31'h3FC90FDB; tag = "R6";
    end else if (fZero(x) && !fZero(y)) begin
      mag = 31'h3FC90FDB; tag = (y[30:23] == 0) ? "R9" : "R7";
    end else if (fZero(y)) begin
      mag = x[31] ? 31'h40490FDB : 31'h0; tag = "R8";
    end else begin
      sp = 1'b0;
      tag = ((x[30:23] == 0) || (y[30:23] == 0)) ? "R9" : "R10";
      return tag;
    end
    res = {y[31], mag};
    return tag;
  endfunction

  function automatic logic [31:0] genOp(input int kind);
    logic [31:0] w;
    logic s;
    s = 1'($urandom);
    case (kind)
      0: w = {s, 31'h0};
      1: w = {s, 8'h00, 23'($urandom) | 23'h1};
      2: w = {s, 8'($urandom_range(1, 254)), 23'($urandom)};
      3: w = {s, 8'hFF, 23'h0};
      4: w = {s, 8'hFF, 1'b1, 22'($urandom)};
      default: w = {s, 8'hFF, 1'b0, 22'($urandom) | 22'h1};
    endcase
    return w;
  endfunction

  function automatic int pickKind();
    int r;
    r = $urandom_range(0, 99);
    if (r < 18) return 0;
    if (r < 28) return 1;
    if (r < 58) return 2;
    if (r < 78) return 3;
    if (r < 89) return 4;
    return 5;
  endfunction

  task automatic checkOne(input logic [31:0] y, input logic [31:0] x);
    bit sp, inv;
    logic [31:0] res;
    string tag;
    tag = refModel(y, x, sp, inv, res);
    @(negedge clk);
    yIn = y; xIn = x; inValid = 1'b1;
    @(negedge clk);
    nChecks++;
    if (outValid !== 1'b1 || outSpecial !== sp || outInvalid !== inv || outResult !== res) begin
      nFail++;
      $display("FAIL %s y=%h x=%h actual v=%b s=%b i=%b r=%h expected v=1 s=%b i=%b r=%h",
               tag, y, x, outValid, outSpecial, outInvalid, outResult, sp, inv, res);
    end
  endtask

  task automatic checkIdle(input logic [31:0] y, input logic [31:0] x);
    @(negedge clk);
    yIn = y; xIn = x; inValid = 1'b0;
    @(negedge clk);
    nChecks++;
    if (outValid !== 1'b0 || outSpecial !== 1'b0 || outInvalid !== 1'b0 || outResult !== 32'h0) begin
      nFail++;
      $display("FAIL R11 idle actual v=%b s=%b i=%b r=%h expected v=0 s=0 i=0 r=00000000",
               outValid, outSpecial, outInvalid, outResult);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    nChecks++; // reset state, R11
    if (outValid !== 1'b0 || outSpecial !== 1'b0 || outResult !== 32'h0) begin
      nFail++;
      $display("FAIL R11 reset actual v=%b s=%b r=%h expected v=0 s=0 r=00000000",
               outValid, outSpecial, outResult);
    end
    rstN = 1'b1;
    // Directed corners (tags noted per line)
    checkOne(32'h7FC0_0001, 32'h7F80_0005); // R1 x sNaN wins over y qNaN, R3 invalid
    checkOne(32'h7F80_0007, 32'h3F80_0000); // R2 y sNaN quietened, R3
    checkOne(32'hFFC0_1234, 32'h0000_0000); // R2 y qNaN, no invalid
    checkOne(32'hFF80_0000, 32'h7F80_0000); // R4 -inf,+inf -> -pi/4 (R12)
    checkOne(32'h8000_0000, 32'h7F80_0000); // R4 -0,+inf -> -0
    checkOne(32'h7F80_0000, 32'hFF80_0000); // R5 -> +3pi/4 (R12)
    checkOne(32'hC000_0000, 32'hFF80_0000); // R5 -> -pi
    checkOne(32'hFF80_0000, 32'h0000_0000); // R6 -> -pi/2
    checkOne(32'h3F80_0000, 32'h8000_0000); // R7 x=-0 -> +pi/2
    checkOne(32'h8000_0000, 32'h8000_0000); // R8 -0,-0 -> -pi
    checkOne(32'h0000_0000, 32'h0000_0000); // R8 +0,+0 -> +0
    checkOne(32'h0000_0000, 32'hBF80_0000); // R8 +0,neg -> +pi
    checkOne(32'h0000_0001, 32'h0000_0000); // R9 subnormal y is nonzero -> pi/2
    checkOne(32'h0000_0000, 32'h8000_0001); // R9 subnormal x, y=+0 -> pi
    checkOne(32'h0000_0003, 32'h0000_0002); // R9 both subnormal -> not special
    checkOne(32'h4000_0000, 32'hC040_0000); // R10 general case
    checkIdle(32'h7F80_0001, 32'h7F80_0001); // R11 no valid, NaN ignored
    checkOne(32'h3F80_0000, 32'h3F80_0000); // R11 valid resumes
    for (int i = 0; i < 3000; i++) begin
      if (i % 97 == 0) checkIdle(genOp(pickKind()), genOp(pickKind()));
      else checkOne(genOp(pickKind()), genOp(pickKind()));
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule